// File: doc/BRIEF.md
# Periodic Autopoll Scheduler

This block issues periodic poll strobes toward a peripheral bus while autopoll is switched on. The period is set in milliseconds and counted from an external millisecond tick. Each poll strobe comes with a 16-bit device-enable mask that tells the bus which devices to query. The bus protocol itself sits outside the block. It answers each poll with a result: a valid pulse, a byte count and up to `MAX_BYTES` bytes.

A result with at least one byte becomes a reply packet. The packet is sent one byte per handshake on a ready/valid stream: first a packet-type byte of 0x00, then a polled-data marker of 0x40, then the returned bytes. A result with no bytes produces no packet. A slow consumer never delays the poll timer, because one result is held in a buffer while polling continues.

Top module: `autopoll_sched`

## Requirements
- R1: After reset the period is 20 ticks, the mask `pollMask` reads 0xFFFF, autopoll is off, and `pollReq` and `pktValid` are low.
- R2: Writing enable=1 while autopoll is off clears the period count. `pollReq` then pulses for one cycle, in the cycle after the edge that samples the rate-th following `msTick`.
- R3: While autopoll is on, a new poll follows every further rate ticks. `pollMask` always shows the most recently written mask, including during a `pollReq` pulse.
- R4: Writing enable=0 while autopoll is on stops the count and discards any partial period. No `pollReq` occurs while autopoll is off.
- R5: An enable write that matches the current state changes nothing. The period in progress continues undisturbed.
- R6: A non-zero rate written while autopoll is on restarts the count, and the next poll falls after the new number of ticks. A rate written while autopoll is off is only stored, and it is used at the next enable.
- R7: A rate write of zero is ignored. Neither the rate nor the period in progress changes.
- R8: An `msTick` in the same cycle as a write that starts, stops or restarts the period is not counted.
- R9: A result with `respLen` from 1 to `MAX_BYTES` raises `pktValid` in the cycle after `respValid`. The bytes sent are 0x00, 0x40, then result bytes in order, where byte i is `respData[8*i+7:8*i]`. The block moves to the next byte on each cycle with `pktValid` and `pktReady` both high. `pktLast` marks the final byte.
- R10: A result with `respLen` of 0 produces no packet.
- R11: While `pktReady` is low, the current byte and `pktValid` hold steady. Polls keep their schedule meanwhile.
- R12: A result that arrives while a packet is still pending, including in the cycle its last byte is accepted, is dropped. The pending packet is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgEnWr | input | 1 | Enable write strobe |
| cfgEnVal | input | 1 | Enable value (1 on, 0 off) |
| cfgRateWr | input | 1 | Rate write strobe |
| cfgRateVal | input | RATE_W | Period in ticks |
| cfgMaskWr | input | 1 | Mask write strobe |
| cfgMaskVal | input | MASK_W | Device-enable mask value |
| msTick | input | 1 | One-cycle millisecond tick |
| pollReq | output | 1 | One-cycle poll strobe |
| pollMask | output | MASK_W | Mask in force |
| respValid | input | 1 | Poll result valid pulse |
| respLen | input | LEN_W | Number of result bytes |
| respData | input | 8*MAX_BYTES | Result bytes, byte 0 in the low bits |
| pktValid | output | 1 | Reply byte valid |
| pktData | output | 8 | Reply byte |
| pktLast | output | 1 | Final byte of the packet |
| pktReady | input | 1 | Consumer accepts the byte |

## Verification
A poll is due in the cycle after the rising edge that samples the expiring tick. A reply packet's first byte is due in the cycle after the edge that samples `respValid`. Each later byte follows the edge that samples an accepted handshake. The bench steps a behavioural model at each rising edge from the same inputs the design sees. It compares every output at the following falling edge, so each result is checked in exactly the cycle it becomes due. Directed checks count polls and collected packet bytes only after idle cycles, once every due result has appeared.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadRate;
    logic loadMask;
    logic capture;
    logic advance;
  } dpCtl_t;

  localparam logic [7:0] PKT_TYPE_BYTE = 8'h00;
  localparam logic [7:0] POLLED_MARKER = 8'h40;

endpackage

// File: rtl/autopoll_ctrl.sv
module autopoll_ctrl
  import autopoll_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgEnWr,
  input  logic              cfgEnVal,
  input  logic              cfgRateWr,
  input  logic [RATE_W-1:0] cfgRateVal,
  input  logic              cfgMaskWr,
  input  logic              msTick,
  input  logic              respValid,
  input  logic              respNonEmpty,
  input  logic              pending,
  input  logic              pktReady,
  input  logic [RATE_W-1:0] rateQ,
  output dpCtl_t            ctl,
  output logic              pollReq
);

  logic              enQ;
  logic [RATE_W-1:0] cntQ;
  logic              enRise, enFall, rateRestart, restart, expire;
  logic [RATE_W-1:0] cntNext;

  assign enRise      = cfgEnWr & cfgEnVal & ~enQ;
  assign enFall      = cfgEnWr & ~cfgEnVal & enQ;
  assign rateRestart = cfgRateWr & (cfgRateVal != '0) & enQ;
  assign restart     = enRise | enFall | rateRestart;
  assign cntNext     = cntQ + RATE_W'(1);
  assign expire      = enQ & msTick & ~restart & (cntNext == rateQ);

  always_comb begin
    ctl          = '0;
    ctl.loadRate = cfgRateWr & (cfgRateVal != '0);
    ctl.loadMask = cfgMaskWr;
    ctl.capture  = respValid & respNonEmpty & ~pending;
    ctl.advance  = pending & pktReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enQ     <= 1'b0;
      cntQ    <= '0;
      pollReq <= 1'b0;
    end else begin
      pollReq <= expire;
      if (enRise) enQ <= 1'b1;
      else if (enFall) enQ <= 1'b0;
      if (restart) cntQ <= '0;
      else if (enQ && msTick) cntQ <= expire ? '0 : cntNext;
    end
  end

  // R3: the count never reaches the period while running
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enQ |-> (cntQ < rateQ));

  // R4: nothing is issued once autopoll is off
  p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enQ |=> !pollReq);

  // R4: a poll strobe always follows a cycle with autopoll on
  p_poll_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pollReq |-> $past(enQ));

endmodule

// File: rtl/autopoll_dp.sv
module autopoll_dp
  import autopoll_pkg::*;
#(
  parameter  int MAX_BYTES  = 8,
  parameter  int RATE_W     = 8,
  parameter  int MASK_W     = 16,
  parameter  int RATE_RESET = 20,
  localparam int LEN_W      = $clog2(MAX_BYTES + 1),
  localparam int IDX_W      = $clog2(MAX_BYTES + 2),
  localparam int BUF_W      = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [RATE_W-1:0] cfgRateVal,
  input  logic [MASK_W-1:0] cfgMaskVal,
  input  logic              respValid,
  input  logic [LEN_W-1:0]  respLen,
  input  logic [BUF_W-1:0]  respData,
  output logic [RATE_W-1:0] rateQ,
  output logic [MASK_W-1:0] maskQ,
  output logic              pendQ,
  output logic [7:0]        pktData,
  output logic              pktLast
);

  logic [IDX_W-1:0] idxQ, lenQ, dataIdx, lastIdx;
  logic [BUF_W-1:0] bufQ, shifted;

  assign dataIdx = idxQ - IDX_W'(2);
  assign lastIdx = lenQ + IDX_W'(1);
  assign shifted = bufQ >> {dataIdx, 3'b000};
  assign pktLast = pendQ & (idxQ == lastIdx);

  always_comb begin
    if (idxQ == IDX_W'(0))      pktData = PKT_TYPE_BYTE;
    else if (idxQ == IDX_W'(1)) pktData = POLLED_MARKER;
    else                        pktData = shifted[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rateQ <= RATE_W'(RATE_RESET);
      maskQ <= '1;
      pendQ <= 1'b0;
      idxQ  <= '0;
      lenQ  <= '0;
      bufQ  <= '0;
    end else begin
      if (ctl.loadRate) rateQ <= cfgRateVal;
      if (ctl.loadMask) maskQ <= cfgMaskVal;
      if (ctl.capture) begin
        pendQ <= 1'b1;
        idxQ  <= '0;
        lenQ  <= IDX_W'(respLen);
        bufQ  <= respData;
      end else if (ctl.advance) begin
        if (pktLast) pendQ <= 1'b0;
        else         idxQ  <= idxQ + IDX_W'(1);
      end
    end
  end

  // R7: a zero period is never held
  p_rate_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rateQ != '0);

  // R9: results fit the buffer
  p_len_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (respLen <= LEN_W'(MAX_BYTES)));

  // R9: every packet opens with the type byte
  p_header_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendQ) |-> (pktData == PKT_TYPE_BYTE));

  // R11: a stalled byte holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ && !ctl.advance) |=> (pendQ && $stable(pktData)));

  // R12: the last accepted byte ends the packet; nothing is captured over it
  p_last_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pktLast && ctl.advance) |=> !pendQ);

endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
  import autopoll_pkg::*;
#(
  parameter  int MAX_BYTES  = 8,
  parameter  int RATE_W     = 8,
  parameter  int MASK_W     = 16,
  parameter  int RATE_RESET = 20,
  localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgEnWr,
  input  logic                   cfgEnVal,
  input  logic                   cfgRateWr,
  input  logic [RATE_W-1:0]      cfgRateVal,
  input  logic                   cfgMaskWr,
  input  logic [MASK_W-1:0]      cfgMaskVal,
  input  logic                   msTick,
  output logic                   pollReq,
  output logic [MASK_W-1:0]      pollMask,
  input  logic                   respValid,
  input  logic [LEN_W-1:0]       respLen,
  input  logic [MAX_BYTES*8-1:0] respData,
  output logic                   pktValid,
  output logic [7:0]             pktData,
  output logic                   pktLast,
  input  logic                   pktReady
);

  dpCtl_t            ctl;
  logic [RATE_W-1:0] rateQ;
  logic              pendQ;

  autopoll_ctrl #(.RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgEnWr(cfgEnWr), .cfgEnVal(cfgEnVal),
    .cfgRateWr(cfgRateWr), .cfgRateVal(cfgRateVal),
    .cfgMaskWr(cfgMaskWr), .msTick(msTick),
    .respValid(respValid), .respNonEmpty(respLen != '0),
    .pending(pendQ), .pktReady(pktReady), .rateQ(rateQ),
    .ctl(ctl), .pollReq(pollReq)
  );

  autopoll_dp #(
    .MAX_BYTES(MAX_BYTES), .RATE_W(RATE_W),
    .MASK_W(MASK_W), .RATE_RESET(RATE_RESET)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .cfgRateVal(cfgRateVal), .cfgMaskVal(cfgMaskVal),
    .respValid(respValid), .respLen(respLen), .respData(respData),
    .rateQ(rateQ), .maskQ(pollMask), .pendQ(pendQ),
    .pktData(pktData), .pktLast(pktLast)
  );

  assign pktValid = pendQ;

endmodule

// File: tb/autopoll_sched_bench.sv
module autopoll_sched_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgEnWr = 0, cfgEnVal = 0, cfgRateWr = 0, cfgMaskWr = 0, msTick = 0;
  logic [7:0]  cfgRateVal = 0;
  logic [15:0] cfgMaskVal = 0;
  logic        respValid = 0, pktReady = 1;
  logic [3:0]  respLen = 0;
  logic [63:0] respData = 0;
  logic        pollReq, pktValid, pktLast;
  logic [15:0] pollMask;
  logic [7:0]  pktData;

  autopoll_sched u_autopoll_sched (
    .clk(clk), .rst_n(rst_n),
    .cfgEnWr(cfgEnWr), .cfgEnVal(cfgEnVal),
    .cfgRateWr(cfgRateWr), .cfgRateVal(cfgRateVal),
    .cfgMaskWr(cfgMaskWr), .cfgMaskVal(cfgMaskVal),
    .msTick(msTick), .pollReq(pollReq), .pollMask(pollMask),
    .respValid(respValid), .respLen(respLen), .respData(respData),
    .pktValid(pktValid), .pktData(pktData), .pktLast(pktLast),
    .pktReady(pktReady)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  function automatic void chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endfunction

  // Behavioural reference model, stepped on each rising edge
  bit         mEn, mPoll, oldEn, restart, wasPend;
  int         mRate, mCnt;
  logic [15:0] mMask;
  logic [7:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = 0; mRate = 20; mMask = 16'hFFFF; mCnt = 0; mPoll = 0; q.delete();
    end else begin
      oldEn = mEn; restart = 0; mPoll = 0; wasPend = (q.size() != 0);
      if (cfgMaskWr) mMask = cfgMaskVal;
      if (cfgRateWr && cfgRateVal != 0) begin
        mRate = cfgRateVal;
        if (oldEn) restart = 1;
      end
      if (cfgEnWr && cfgEnVal != oldEn) begin mEn = cfgEnVal; restart = 1; end
      if (restart) mCnt = 0;
      else if (oldEn && msTick) begin
        mCnt++;
        if (mCnt == mRate) begin mPoll = 1; mCnt = 0; end
      end
      if (wasPend && pktReady) void'(q.pop_front());
      if (respValid && respLen != 0 && !wasPend) begin
        q.push_back(8'h00); q.push_back(8'h40);
        for (int i = 0; i < respLen; i++) q.push_back(respData[8*i +: 8]);
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(pollReq === mPoll, "R3 pollReq timing", pollReq, mPoll);
      chk(pollMask === mMask, "R3 pollMask", pollMask, mMask);
      chk(pktValid === (q.size() != 0), "R9 pktValid", pktValid, q.size() != 0);
      if (q.size() != 0) begin
        chk(pktData === q[0], "R9 pktData", pktData, q[0]);
        chk(pktLast === (q.size() == 1), "R9 pktLast", pktLast, q.size() == 1);
      end
    end
  end

  // Observers
  int pollCount = 0, pktCount = 0;
  logic [15:0] lastPollMask;
  logic [63:0] seen;
  int seenN;
  always @(posedge clk) begin
    if (rst_n) begin
      if (pollReq) begin pollCount++; lastPollMask = pollMask; end
      if (pktValid && pktReady) begin
        seen = {seen[55:0], pktData}; seenN++;
        if (pktLast) pktCount++;
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic ticks(int n);
    repeat (n) begin msTick = 1; @(negedge clk); msTick = 0; @(negedge clk); end
  endtask
  task automatic wrEn(bit v);
    cfgEnWr = 1; cfgEnVal = v; @(negedge clk); cfgEnWr = 0;
  endtask
  task automatic wrRate(logic [7:0] v, bit withTick);
    cfgRateWr = 1; cfgRateVal = v; msTick = withTick; @(negedge clk);
    cfgRateWr = 0; msTick = 0;
  endtask
  task automatic wrMask(logic [15:0] v);
    cfgMaskWr = 1; cfgMaskVal = v; @(negedge clk); cfgMaskWr = 0;
  endtask
  task automatic resp(int len, logic [63:0] d);
    respValid = 1; respLen = 4'(len); respData = d; @(negedge clk);
    respValid = 0;
  endtask
  task automatic clrSeen(); seen = 0; seenN = 0; endtask

  int base;

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk(pollReq == 0, "R1 pollReq after reset", pollReq, 0);
    chk(pktValid == 0, "R1 pktValid after reset", pktValid, 0);
    chk(pollMask == 16'hFFFF, "R1 mask after reset", pollMask, 16'hFFFF);

    // R1/R2: default period of 20 from enable
    wrEn(1); base = pollCount;
    ticks(19); cyc(2);
    chk(pollCount == base, "R2 no poll before period", pollCount - base, 0);
    ticks(1); cyc(2);
    chk(pollCount == base + 1, "R1 R2 poll at 20th tick", pollCount - base, 1);

    // R3: periodic with new mask
    wrMask(16'h1234); base = pollCount;
    ticks(20); cyc(2);
    chk(pollCount == base + 1, "R3 next period", pollCount - base, 1);
    chk(lastPollMask == 16'h1234, "R3 mask on poll", lastPollMask, 16'h1234);

    // R5: redundant enable write
    base = pollCount;
    ticks(5); wrEn(1); ticks(15); cyc(2);
    chk(pollCount == base + 1, "R5 same-state write ignored", pollCount - base, 1);

    // R6: rate change while running restarts
    base = pollCount;
    ticks(10); wrRate(5, 0); ticks(4); cyc(2);
    chk(pollCount == base, "R6 restart no early poll", pollCount - base, 0);
    ticks(1); cyc(2);
    chk(pollCount == base + 1, "R6 poll at new rate", pollCount - base, 1);

    // R7: zero rate ignored
    base = pollCount;
    ticks(2); wrRate(0, 0); ticks(3); cyc(2);
    chk(pollCount == base + 1, "R7 zero rate ignored", pollCount - base, 1);

    // R8: tick coincident with restarting write is dropped
    base = pollCount;
    wrRate(3, 1); ticks(2); cyc(2);
    chk(pollCount == base, "R8 coincident tick dropped", pollCount - base, 0);
    ticks(1); cyc(2);
    chk(pollCount == base + 1, "R8 poll after 3 counted", pollCount - base, 1);

    // R4: disable stops, R6: rate stored while off
    ticks(2); wrEn(0); base = pollCount;
    ticks(10); wrRate(4, 0); ticks(6); cyc(2);
    chk(pollCount == base, "R4 no poll while off", pollCount - base, 0);
    wrEn(1); ticks(3); cyc(2);
    chk(pollCount == base, "R6 stored rate not yet", pollCount - base, 0);
    ticks(1); cyc(2);
    chk(pollCount == base + 1, "R6 stored rate used", pollCount - base, 1);
    wrEn(0);

    // R9: packet format
    pktReady = 1; clrSeen(); base = pktCount;
    resp(3, 64'hCCBBAA);
    chk(pktValid == 1, "R9 valid one cycle after result", pktValid, 1);
    cyc(8);
    chk(pktCount == base + 1, "R9 one packet", pktCount - base, 1);
    chk(seenN == 5 && seen[39:0] == 40'h0040AABBCC, "R9 byte order", seen[39:0], 40'h0040AABBCC);

    // R10: empty result
    base = pktCount;
    resp(0, 64'h55); cyc(1);
    chk(pktValid == 0, "R10 no packet for empty result", pktValid, 0);
    cyc(4);
    chk(pktCount == base, "R10 packet count", pktCount - base, 0);

    // R11: stall holds, polls continue
    wrRate(2, 0); wrEn(1); base = pollCount;
    pktReady = 0; clrSeen();
    resp(2, 64'h2211); ticks(4); cyc(2);
    chk(pktValid == 1 && pktData == 8'h00, "R11 byte held", {pktValid, pktData}, 9'h100);
    chk(pollCount == base + 2, "R11 polls not delayed", pollCount - base, 2);
    pktReady = 1; cyc(6);
    chk(seenN == 4 && seen[31:0] == 32'h00401122, "R11 bytes after stall", seen[31:0], 32'h00401122);
    wrEn(0);

    // R12: result while pending dropped
    pktReady = 0; clrSeen(); base = pktCount;
    resp(1, 64'h11); cyc(1); resp(2, 64'h3322);
    pktReady = 1; cyc(8);
    chk(pktCount == base + 1, "R12 second result dropped", pktCount - base, 1);
    chk(seenN == 3 && seen[23:0] == 24'h004011, "R12 pending bytes kept", seen[23:0], 24'h004011);

    cyc(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule